// File: doc/BRIEF.md
# Transfer FIFO with Watermark Status

This block is the byte queue between a register-mapped host port and a bus timing engine. On a write transfer the host fills it and the engine drains it. On a read transfer the engine fills it from the bus and the host drains it. The block drives the raw status bits that a control/status register shows: service requests for both directions, empty, full, room and data-present flags, and a sticky access error. It also shows the current occupancy and the largest occupancy seen since the last transfer start.

A transfer start loads a pad count of zero to three bytes. For a write transfer, that many bytes are discarded from the head of the queue before the engine can see data. For a read transfer, that many of the first bytes arriving from the bus are thrown away before storing begins. A clear command empties the queue at once.

Top module: `xfer_fifo`

## Requirements
- R1: After reset the occupancy is 0, the peak is 0, the empty and low-watermark request bits are 1, and the error, full and high-watermark request bits are 0.
- R2: Bytes leave the queue in the order they entered. `popData` shows the head while `popReady` is high. Each stored push adds one to `fillCount` and each accepted pop subtracts one. In a cycle with no push, pop or clear, the count holds.
- R3: `txReq` is 1 exactly when `fillCount` is below DEPTH/4 (below 8 for 32 entries).
- R4: `rxReq` is 1 when `fillCount` is at least 3*DEPTH/4 (24 for 32 entries). It is also 1 when `xferDone` is high and `fillCount` is non-zero.
- R5: `txHasRoom` means count < DEPTH, `rxHasData` means count > 0, `txEmpty` means count == 0, and `rxFull` means count == DEPTH.
- R6: A push while full, or a pop while empty, changes neither the count nor the contents. It sets `accessErr` on the next edge.
- R7: `accessErr` stays set until a cycle with `errClr` high. If a new illegal access comes in the same cycle as `errClr`, the error stays set.
- R8: On the edge that takes `xferStart`, `peakCount` takes the occupancy left by that edge. After that it rises to any larger occupancy and never falls until the next start.
- R9: A write start (`xferWrite`=1) with pad N drops the N oldest bytes, one per cycle while the queue holds data. `popReady` stays low until all N are gone.
- R10: A read start (`xferWrite`=0) with pad N throws away the next N pushes without storing them and without raising an error.
- R11: `clearCmd` empties the queue on the next edge and overrides a push or pop in the same cycle. It leaves `accessErr` and `peakCount` unchanged.
- R12: A push and a pop in the same cycle, both legal, store and remove one byte each, and the count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushEn | input | 1 | Push request |
| pushData | input | 8 | Byte to push |
| popEn | input | 1 | Pop request |
| popData | output | 8 | Head byte |
| popReady | output | 1 | Head is valid and no leading drop is pending |
| xferStart | input | 1 | Transfer start pulse |
| xferWrite | input | 1 | Direction taken at start: 1 write, 0 read |
| padCfg | input | 2 | Leading bytes to discard, taken at start |
| xferDone | input | 1 | Transfer finished level |
| clearCmd | input | 1 | Empty the queue |
| errClr | input | 1 | Clear the sticky error |
| txReq | output | 1 | Low-watermark service request |
| rxReq | output | 1 | High-watermark or done-with-data request |
| txHasRoom | output | 1 | Not full |
| rxHasData | output | 1 | Not empty |
| txEmpty | output | 1 | Empty |
| rxFull | output | 1 | Full |
| accessErr | output | 1 | Sticky overflow/underflow error |
| fillCount | output | 6 | Current occupancy |
| peakCount | output | 6 | Highest occupancy since the last start |

## Verification
The bench steps the occupancy across both watermark thresholds, 7/8 and 23/24. A comparison off by one would move a request bit one entry early or late. It pushes into a full queue and pops from an empty one. A design that still moved its pointers would lose a byte or replay a stale one, and the scoreboard would catch the mismatch. It sends `errClr` together with a fresh illegal access, and a clear together with a push, to pin down which one wins. Finally it runs padded transfers in both directions. A design that dropped bytes from the wrong end would deliver the wrong byte to the scoreboard, and a peak that was not restarted would still read 32.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic start;
  } fifoStrobes_t;
endpackage

// File: rtl/xfer_fifo_dp.sv
module xfer_fifo_dp
  import xfer_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobe,
  input  logic [DATA_W-1:0] pushData,
  input  logic              xferDone,
  output logic [DATA_W-1:0] popData,
  output logic [CNT_W-1:0]  fillCount,
  output logic [CNT_W-1:0]  peakCount,
  output logic              isEmpty,
  output logic              isFull,
  output logic              lowReq,
  output logic              highReq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] LOW_MARK  = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] HIGH_MARK = CNT_W'((3 * DEPTH) / 4);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  countNext;
  logic              doWrite, doRead;

  assign doWrite = strobe.push && !strobe.flush;
  assign doRead  = strobe.pop  && !strobe.flush;

  always_comb begin
    if (strobe.flush) countNext = '0;
    else countNext = fillCount + {{(CNT_W-1){1'b0}}, doWrite}
                               - {{(CNT_W-1){1'b0}}, doRead};
  end

  always_ff @(posedge clk) begin
    if (doWrite) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
      peakCount <= '0;
    end else begin
      if (strobe.flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (doWrite) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
        if (doRead)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      end
      fillCount <= countNext;
      if (strobe.start)            peakCount <= countNext;
      else if (countNext > peakCount) peakCount <= countNext;
    end
  end

  assign popData = store[rdPtr];
  assign isEmpty = (fillCount == '0);
  assign isFull  = (fillCount == FULL_CNT);
  assign lowReq  = (fillCount < LOW_MARK);
  assign highReq = (fillCount >= HIGH_MARK) || (xferDone && !isEmpty);

  // R5: occupancy never exceeds the depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULL_CNT);
  // R8: peak never below the current occupancy
  p_peak_ge_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    peakCount >= fillCount);
  // R11: a clear leaves the queue empty
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (fillCount == '0));
  // R2: idle cycle keeps occupancy
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.push && !strobe.pop && !strobe.flush) |=> $stable(fillCount));
  // R6: the control never stores into a full queue
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !isFull);
  // R6: the control never reads an empty queue
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !isEmpty);
endmodule

// File: rtl/xfer_fifo_ctrl.sv
module xfer_fifo_ctrl
  import xfer_fifo_pkg::*;
#(
  parameter int PAD_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic             popEn,
  input  logic             xferStart,
  input  logic             xferWrite,
  input  logic [PAD_W-1:0] padCfg,
  input  logic             clearCmd,
  input  logic             errClr,
  input  logic             isEmpty,
  input  logic             isFull,
  output fifoStrobes_t     strobe,
  output logic             popReady,
  output logic             accessErr
);
  logic             dirWrite;
  logic [PAD_W-1:0] dropLeft;
  logic             padPending, dropping, skipping;
  logic             pushSkip, pushStore, pushBad;
  logic             dropPop, userPop, popBad;

  assign padPending = (dropLeft != '0);
  assign dropping   = dirWrite && padPending;
  assign skipping   = !dirWrite && padPending;

  assign pushSkip  = pushEn && skipping;
  assign pushStore = pushEn && !skipping && !isFull;
  assign pushBad   = pushEn && !skipping && isFull;

  assign dropPop = dropping && !isEmpty;
  assign userPop = popEn && !dropping && !isEmpty;
  assign popBad  = popEn && isEmpty;

  always_comb begin
    strobe.push  = pushStore;
    strobe.pop   = dropPop || userPop;
    strobe.flush = clearCmd;
    strobe.start = xferStart;
  end

  assign popReady = !isEmpty && !dropping;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirWrite  <= 1'b1;
      dropLeft  <= '0;
      accessErr <= 1'b0;
    end else begin
      if (xferStart) begin
        dirWrite <= xferWrite;
        dropLeft <= padCfg;
      end else if (dropPop || pushSkip) begin
        dropLeft <= dropLeft - 1'b1;
      end
      if (pushBad || popBad) accessErr <= 1'b1;
      else if (errClr)       accessErr <= 1'b0;
    end
  end

  // R6: push into a full queue flags the error
  p_push_full_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && isFull && !skipping) |=> accessErr);
  // R6: pop from an empty queue flags the error
  p_pop_empty_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && isEmpty) |=> accessErr);
  // R7: clear with no new illegal access drops the error
  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !(pushEn && isFull) && !(popEn && isEmpty)) |=> !accessErr);
  // R7: error is sticky without a clear
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accessErr && !errClr) |=> accessErr);
  // R9: ready only with data present
  p_ready_has_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    popReady |-> !isEmpty);
endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo
  import xfer_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int PAD_W  = 2,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  output logic [DATA_W-1:0] popData,
  output logic              popReady,
  input  logic              xferStart,
  input  logic              xferWrite,
  input  logic [PAD_W-1:0]  padCfg,
  input  logic              xferDone,
  input  logic              clearCmd,
  input  logic              errClr,
  output logic              txReq,
  output logic              rxReq,
  output logic              txHasRoom,
  output logic              rxHasData,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              accessErr,
  output logic [CNT_W-1:0]  fillCount,
  output logic [CNT_W-1:0]  peakCount
);
  fifoStrobes_t strobe;
  logic isEmpty, isFull;

  xfer_fifo_ctrl #(.PAD_W(PAD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn),
    .xferStart(xferStart), .xferWrite(xferWrite), .padCfg(padCfg),
    .clearCmd(clearCmd), .errClr(errClr), .isEmpty(isEmpty), .isFull(isFull),
    .strobe(strobe), .popReady(popReady), .accessErr(accessErr)
  );

  xfer_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushData(pushData),
    .xferDone(xferDone), .popData(popData), .fillCount(fillCount),
    .peakCount(peakCount), .isEmpty(isEmpty), .isFull(isFull),
    .lowReq(txReq), .highReq(rxReq)
  );

  assign txHasRoom = !isFull;
  assign rxHasData = !isEmpty;
  assign txEmpty   = isEmpty;
  assign rxFull    = isFull;
endmodule

// File: tb/xfer_fifo_tb_top.sv
module xfer_fifo_tb_top;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushEn = 1'b0, popEn = 1'b0, xferStart = 1'b0, xferWrite = 1'b0;
  logic xferDone = 1'b0, clearCmd = 1'b0, errClr = 1'b0;
  logic [7:0] pushData = '0;
  logic [1:0] padCfg = '0;
  logic [7:0] popData;
  logic popReady, txReq, rxReq, txHasRoom, rxHasData, txEmpty, rxFull, accessErr;
  logic [5:0] fillCount, peakCount;

  int vecCount = 0;
  int failCount = 0;
  logic [7:0] expQ[$];
  bit mErr = 0;
  bit mDirWrite = 1;
  int mSkip = 0;
  int mPeak = 0;

  always #4 clk = ~clk;

  xfer_fifo dut_i (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushData(pushData),
    .popEn(popEn), .popData(popData), .popReady(popReady),
    .xferStart(xferStart), .xferWrite(xferWrite), .padCfg(padCfg),
    .xferDone(xferDone), .clearCmd(clearCmd), .errClr(errClr),
    .txReq(txReq), .rxReq(rxReq), .txHasRoom(txHasRoom), .rxHasData(rxHasData),
    .txEmpty(txEmpty), .rxFull(rxFull), .accessErr(accessErr),
    .fillCount(fillCount), .peakCount(peakCount)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkStat(input string req);
    int n;
    logic [13:0] act, exp;
    n = expQ.size();
    act = {txReq, rxReq, txHasRoom, rxHasData, txEmpty, rxFull, accessErr, 1'b0, fillCount};
    exp = {n < 8, (n >= 24) || (xferDone && n != 0), n < DEPTH, n > 0, n == 0,
           n == DEPTH, mErr, 1'b0, 6'(n)};
    chk(req, 32'(act), 32'(exp));
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // driver side of the scoreboard: predicts storage
  task automatic modelPush(input logic [7:0] d, input bit peakTrack);
    if (!mDirWrite && mSkip > 0) mSkip--;
    else if (expQ.size() >= DEPTH) mErr = 1;
    else begin
      expQ.push_back(d);
      if (peakTrack && expQ.size() > mPeak) mPeak = expQ.size();
    end
  endtask

  task automatic push(input logic [7:0] d);
    pushEn = 1; pushData = d; modelPush(d, 1);
    tick();
    pushEn = 0;
  endtask

  task automatic pop();
    popEn = 1;
    tick();
    popEn = 0;
  endtask

  task automatic pushPop(input logic [7:0] d);
    pushEn = 1; pushData = d; popEn = 1; modelPush(d, 0);
    tick();
    pushEn = 0; popEn = 0;
  endtask

  task automatic startXfer(input bit wr, input logic [1:0] pad);
    xferStart = 1; xferWrite = wr; padCfg = pad;
    tick();
    xferStart = 0;
    mDirWrite = wr;
    mPeak = expQ.size();
    if (wr) begin
      for (int i = 0; i < pad; i++) void'(expQ.pop_front());
      mSkip = 0;
    end else mSkip = pad;
  endtask

  // monitor side of the scoreboard: compares each popped byte
  always @(negedge clk) begin
    if (rstN && popEn) begin
      if (expQ.size() == 0) begin
        chk("R6 pop-empty ready", 32'(popReady), 32'd0);
        mErr = 1;
      end else begin
        chk("R2 ready", 32'(popReady), 32'd1);
        chk("R2 order", 32'(popData), 32'(expQ[0]));
        void'(expQ.pop_front());
      end
    end
  end

  initial begin
    #(8 * 200000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    settle();
    chkStat("R1 reset");
    chk("R1 peak", 32'(peakCount), 32'd0);

    for (int i = 0; i < 7; i++) push(8'h10 + 8'(i));
    settle(); chkStat("R3 seven");
    push(8'h17);
    settle(); chkStat("R3 eight");
    pop(); pop();
    settle(); chkStat("R2 after pops");

    while (expQ.size() < 23) push(8'h20 + 8'(expQ.size()));
    settle(); chkStat("R4 at 23");
    push(8'h60);
    settle(); chkStat("R4 at 24");
    while (expQ.size() < DEPTH) push(8'h80 + 8'(expQ.size()));
    settle(); chkStat("R5 full");
    chk("R8 peak full", 32'(peakCount), 32'(mPeak));

    push(8'hEE);
    settle(); chkStat("R6 push-full");
    errClr = 1; push(8'hEF); errClr = 0;
    settle(); chkStat("R7 set wins");
    errClr = 1; tick(); errClr = 0; mErr = 0;
    settle(); chkStat("R7 cleared");

    pop();
    pushPop(8'hAA);
    settle(); chkStat("R12 push+pop");

    clearCmd = 1; pushEn = 1; pushData = 8'h55;
    tick();
    clearCmd = 0; pushEn = 0;
    expQ.delete();
    settle(); chkStat("R11 clear");
    chk("R11 peak kept", 32'(peakCount), 32'(mPeak));

    pop();
    settle(); chkStat("R6 pop-empty");
    errClr = 1; tick(); errClr = 0; mErr = 0;

    push(8'h33);
    xferDone = 1;
    settle(); chkStat("R4 done with data");
    pop();
    settle(); chkStat("R4 done empty");
    xferDone = 0;

    for (int i = 0; i < 4; i++) push(8'h40 + 8'(i));
    startXfer(1, 2'd2);
    settle();
    chk("R8 peak restart", 32'(peakCount), 32'd4);
    chk("R9 ready low while dropping", 32'(popReady), 32'd0);
    repeat (3) tick();
    settle(); chkStat("R9 after drop");
    chk("R9 ready", 32'(popReady), 32'd1);
    pop(); pop();
    for (int i = 0; i < 5; i++) push(8'h50 + 8'(i));
    settle(); chk("R8 peak rises", 32'(peakCount), 32'(mPeak));
    while (expQ.size() > 0) pop();

    startXfer(0, 2'd3);
    settle(); chk("R8 peak restart empty", 32'(peakCount), 32'd0);
    for (int i = 0; i < 5; i++) push(8'h70 + 8'(i));
    settle(); chkStat("R10 read pad");
    pop(); pop();
    settle(); chkStat("R10 drained");

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule